// File: doc/BRIEF.md
# Vector Mask Reduction Unit

This block runs one mask operation over a short vector of eight elements. Each element contributes a single mask bit, and only the first `vl` elements take part. The unit offers five operations. Two give a scalar result: the position of the first set bit, and the number of set bits. Three give a vector result: a running exclusive count of set bits (iota), and two prefix flag patterns that mark the elements before the first set bit, either excluding or including that element.

Iota and the two flag operations can be limited further by an optional governing mask. When it is enabled, an element whose governing bit is 0 is inactive. It is skipped by the count and receives zero. A caller pulses `start` with all operands valid. The results are registered and appear with a single-cycle `done` pulse in the following cycle. They then hold until the next `start`.

Top module: `vmask_reduce`

## Requirements
- R1: When `start` is sampled high at a rising edge, `done` is high in the next cycle, and low in any cycle not preceded by a `start`. `scalar_res` and `vec_res` change only on an edge where `start` is high, and otherwise hold their values.
- R2: Operation code 0 (find-first) returns the index of the lowest set bit among elements below `vl`. It returns all ones in `XW` bits when no such bit is set. The governing mask has no effect on it, and `vec_res` is zero.
- R3: Operation code 1 (count) returns the number of set bits among elements below `vl`. The governing mask has no effect on it, and `vec_res` is zero.
- R4: Operation code 2 (iota) writes into element i of `vec_res` the number of set source bits in active elements with an index below i. Element i occupies bits [i*EW +: EW]. `scalar_res` is zero.
- R5: Operation code 3 (flag-before-first) sets the least significant bit of each active element that lies before the first active set source bit to 1. It clears that bit from the first set element onward. All other element bits are zero.
- R6: Operation code 4 (flag-including-first) sets the least significant bit to 1 for each active element up to and including the first active set source bit, and to 0 after it.
- R7: When no active source bit is set, flag-before-first and flag-including-first both set every active element to 1.
- R8: With `gov_en` high, an element whose `gov_mask` bit is 0 is inactive for iota and the two flag operations. It does not count, cannot be the first set bit, and its result element is zero.
- R9: Elements at an index of `vl` or above are excluded from every operation, and their result elements are zero. A `vl` above 8 acts as 8, and a `vl` of 0 gives an all-zero vector result.
- R10: While `rst_n` is low, `done`, `scalar_res` and `vec_res` are zero.
- R11: Operation codes 5 to 7 are reserved and give zero in both `scalar_res` and `vec_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample operands and compute this cycle |
| op | input | 3 | Operation code (0 find-first, 1 count, 2 iota, 3 flag-before-first, 4 flag-including-first) |
| vl | input | VLW (4) | Active vector length |
| src_mask | input | NELEM (8) | Source mask bits, bit i for element i |
| gov_mask | input | NELEM (8) | Governing mask bits |
| gov_en | input | 1 | Apply the governing mask to iota and flag operations |
| scalar_res | output | XW (16) | Find-first index or count |
| vec_res | output | NELEM*EW (64) | Vector result, element i in bits [i*EW +: EW] |
| done | output | 1 | Result valid pulse |

## Verification
The hardest case to reach combines the governing mask with `vl` so that the lowest set source bit is inactive. The true first set bit then lies further up, and some inactive elements sit between active ones below `vl`. Table entries reach this case directly: they place a set source bit under a cleared governing bit and clear more governing bits in the middle of the active range. These entries check iota counts and both flag patterns against hand-worked element values. Separate entries cover the same masks with the governing mask ignored by find-first and count, a `vl` above the element count, and a `vl` of zero.

// File: rtl/vmask_reduce.sv
module vmask_reduce #(
  parameter int NELEM = 8,
  parameter int EW    = 8,
  parameter int XW    = 16,
  parameter int VLW   = $clog2(NELEM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [VLW-1:0]      vl,
  input  logic [NELEM-1:0]    src_mask,
  input  logic [NELEM-1:0]    gov_mask,
  input  logic                gov_en,
  output logic [XW-1:0]       scalar_res,
  output logic [NELEM*EW-1:0] vec_res,
  output logic                done
);
  localparam logic [2:0] OP_FIRST = 3'd0;
  localparam logic [2:0] OP_COUNT = 3'd1;
  localparam logic [2:0] OP_IOTA  = 3'd2;
  localparam logic [2:0] OP_BEF   = 3'd3;
  localparam logic [2:0] OP_INC   = 3'd4;

  logic                use_gov;
  logic [XW-1:0]       cnt, first_idx, nxt_sc;
  logic [NELEM*EW-1:0] nxt_vec;
  logic                seen, act, hit;

  assign use_gov = gov_en && (op == OP_IOTA || op == OP_BEF || op == OP_INC);

  always_comb begin
    cnt       = '0;
    first_idx = '1;
    seen      = 1'b0;
    nxt_vec   = '0;
    act       = 1'b0;
    hit       = 1'b0;
    for (int i = 0; i < NELEM; i++) begin
      act = (i < int'(vl)) && (!use_gov || gov_mask[i]);
      hit = act && src_mask[i];
      case (op)
        OP_IOTA: if (act) nxt_vec[i*EW +: EW] = EW'(cnt);
        OP_BEF:  if (act && !seen && !hit) nxt_vec[i*EW] = 1'b1;
        OP_INC:  if (act && !seen) nxt_vec[i*EW] = 1'b1;
        default: ;
      endcase
      if (hit && !seen) first_idx = XW'(i);
      if (hit) cnt = cnt + XW'(1);
      seen = seen | hit;
    end
  end

  assign nxt_sc = (op == OP_FIRST) ? first_idx :
                  (op == OP_COUNT) ? cnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scalar_res <= '0;
      vec_res    <= '0;
      done       <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        scalar_res <= nxt_sc;
        vec_res    <= nxt_vec;
      end
    end
  end
endmodule

// File: rtl/vmask_reduce_chk.sv
module vmask_reduce_chk #(
  parameter int NELEM = 8,
  parameter int EW    = 8,
  parameter int XW    = 16,
  parameter int VLW   = $clog2(NELEM + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [2:0]          op,
  input logic [VLW-1:0]      vl,
  input logic [NELEM-1:0]    src_mask,
  input logic [XW-1:0]       scalar_res,
  input logic [NELEM*EW-1:0] vec_res,
  input logic                done
);
  // R1
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(scalar_res) && $stable(vec_res)));
  // R2
  first_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd0 && src_mask == '0) |=> (scalar_res == '1));
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd1) |=> (scalar_res <= XW'($past(vl))));
  // R9
  vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vl == '0) |=> (vec_res == '0));
  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op > 3'd4) |=> (scalar_res == '0 && vec_res == '0));
endmodule

bind vmask_reduce vmask_reduce_chk #(.NELEM(NELEM), .EW(EW), .XW(XW), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vl(vl), .src_mask(src_mask),
  .scalar_res(scalar_res), .vec_res(vec_res), .done(done)
);

// File: tb/vmask_reduce_bench.sv
module vmask_reduce_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  vl = '0;
  logic [7:0]  src_mask = '0;
  logic [7:0]  gov_mask = '0;
  logic        gov_en = 1'b0;
  logic [15:0] scalar_res;
  logic [63:0] vec_res;
  logic        done;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vmask_reduce u_vmask_reduce (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vl(vl),
    .src_mask(src_mask), .gov_mask(gov_mask), .gov_en(gov_en),
    .scalar_res(scalar_res), .vec_res(vec_res), .done(done)
  );

  // {op, vl, gov_en, gov_mask, src_mask, scalar, vector}
  localparam int NV = 15;
  localparam logic [103:0] TBL [NV] = '{
    {3'd0, 4'd8,  1'b0, 8'h00, 8'h28, 16'd3,     64'h0},                    // R2
    {3'd0, 4'd3,  1'b0, 8'h00, 8'h28, 16'hFFFF,  64'h0},                    // R2 R9
    {3'd1, 4'd8,  1'b0, 8'h00, 8'hB5, 16'd5,     64'h0},                    // R3
    {3'd1, 4'd5,  1'b1, 8'h00, 8'hB5, 16'd3,     64'h0},                    // R3
    {3'd2, 4'd8,  1'b0, 8'h00, 8'h96, 16'd0,     64'h0303_0302_0201_0000},  // R4
    {3'd2, 4'd6,  1'b1, 8'hF5, 8'hFF, 16'd0,     64'h0000_0302_0001_0000},  // R8 R9
    {3'd3, 4'd8,  1'b0, 8'h00, 8'h10, 16'd0,     64'h0000_0000_0101_0101},  // R5
    {3'd4, 4'd8,  1'b0, 8'h00, 8'h10, 16'd0,     64'h0000_0001_0101_0101},  // R6
    {3'd3, 4'd5,  1'b0, 8'h00, 8'h00, 16'd0,     64'h0000_0001_0101_0101},  // R7
    {3'd4, 4'd6,  1'b1, 8'hFA, 8'h21, 16'd0,     64'h0000_0101_0100_0100},  // R6 R8
    {3'd3, 4'd6,  1'b1, 8'hFA, 8'h21, 16'd0,     64'h0000_0001_0100_0100},  // R5 R8
    {3'd5, 4'd8,  1'b0, 8'h00, 8'hFF, 16'd0,     64'h0},                    // R11
    {3'd1, 4'd15, 1'b0, 8'h00, 8'hFF, 16'd8,     64'h0},                    // R9
    {3'd2, 4'd0,  1'b0, 8'h00, 8'hFF, 16'd0,     64'h0},                    // R9
    {3'd0, 4'd8,  1'b1, 8'h00, 8'h80, 16'd7,     64'h0}                     // R2
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [3:0] l, input logic ge,
                       input logic [7:0] g, input logic [7:0] s);
    @(negedge clk);
    op = o; vl = l; gov_en = ge; gov_mask = g; src_mask = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : watchdog
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 done", 64'(done), 64'd0);
    check("R10 scalar", 64'(scalar_res), 64'd0);
    check("R10 vector", vec_res, 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      issue(TBL[k][103:101], TBL[k][100:97], TBL[k][96], TBL[k][95:88], TBL[k][87:80]);
      check($sformatf("R1 done row %0d", k), 64'(done), 64'd1);
      check($sformatf("scalar row %0d", k), 64'(scalar_res), 64'(TBL[k][79:64]));
      check($sformatf("vector row %0d", k), vec_res, TBL[k][63:0]);
    end

    // R1: single pulse, results hold while operands change without start
    issue(3'd1, 4'd8, 1'b0, 8'h00, 8'h0F);
    @(negedge clk);
    op = 3'd2; src_mask = 8'hFF; vl = 4'd8;
    check("R1 done low", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    check("R1 scalar hold", 64'(scalar_res), 64'd4);
    check("R1 vector hold", vec_res, 64'd0);

    // R8: governing mask disabled leaves all elements active for flag-including-first
    issue(3'd4, 4'd6, 1'b0, 8'hFA, 8'h21);
    check("R8 gov off", vec_res, 64'h0000_0000_0000_0001);

    // R10: reset mid-operation clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 reset scalar", 64'(scalar_res), 64'd0);
    check("R10 reset vector", vec_res, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule